// File: doc/BRIEF.md
# Quad-Rate Four-Word Burst SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM with one data input bus for writes, a separate data output bus for reads, and one address bus that both ports share. Read and write bursts run at the same time and never contend for a bus. Each burst moves four words, one word per clock edge of the complementary input clock pair. A burst therefore spans two input-clock cycles, and a new read and a new write may start in every such frame.

The model runs from one clock, `clk`. Each rising edge of `clk` stands for one rising edge of either the true input clock or its complement. A free-running two-bit slot counter numbers these edges 0 to 3. Slots 0 and 2 are true-clock edges and slots 1 and 3 are complement edges. The read address is taken on slot 0 and the write address on slot 1. A latency-mode input selects the read latency: 1.5 cycles, the timing with the delay-locked loop running, or 1 cycle, the timing with that loop off.

An echo clock is driven beside the read data so that a receiver can capture each word. Reads always return the newest data, including a write whose last word is still arriving on the edge where the read address is taken.

Top module: `qburst_sram`

## Requirements
- R1: While `rst_n` is low, `rd_valid`, `rd_data`, `echo_clk` and `edge_slot` are all 0. The first `clk` edge after release is slot 0.
- R2: `edge_slot` shows the slot of the next edge and steps 0,1,2,3,0 on each edge. `addr` and `rd_sel_n` are used only on the slot-0 edge, and `addr` and `wr_sel_n` only on the slot-1 edge. On slots 2 and 3, the address and both selects have no effect.
- R3: When `wr_sel_n` is low on a slot-1 edge, the `wr_data` values on that edge and on the next three edges (slots 2, 3 and the next slot 0) are stored as words 0, 1, 2 and 3 of the burst address taken on that slot-1 edge.
- R4: When `rd_sel_n` is low on a slot-0 edge, words 0, 1, 2 and 3 of the addressed burst appear in that order on four consecutive edges, and `rd_valid` is high for exactly those edges.
- R5: When `dll_on`=1, word 0 is registered on the third edge after the read-address edge (slot 3). When `dll_on`=0, it is registered on the second edge (slot 2). `dll_on` may change only while no read is in flight.
- R6: A high select on its sampling edge means no operation: no words are stored if `wr_sel_n` is high, and no `rd_valid` appears if `rd_sel_n` is high.
- R7: A read returns every write issued in earlier frames, including word 3 of the previous frame's write, which arrives on the read's own address edge. It does not return the write issued one edge later in the same frame.
- R8: Reads issued in consecutive frames produce an unbroken stream of words with `rd_valid` high on every edge.
- R9: While `rd_valid` is low, `rd_data` keeps its previous value.
- R10: `echo_clk` toggles on every edge. It is 1 after a true-clock edge (slots 0 and 2) and 0 after a complement edge (slots 1 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Edge clock; each rising edge is one true or complement input-clock edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_on | input | 1 | Latency mode: 1 gives 1.5-cycle reads, 0 gives 1-cycle reads |
| addr | input | ADDR_W | Shared burst address (read on slot 0, write on slot 1) |
| rd_sel_n | input | 1 | Active-low read port select, sampled on slot 0 |
| wr_sel_n | input | 1 | Active-low write port select, sampled on slot 1 |
| wr_data | input | WORD_W | Write data, one word per edge |
| rd_data | output | WORD_W | Registered read data, one word per edge |
| rd_valid | output | 1 | High on edges that register a read word |
| echo_clk | output | 1 | Echo clock aligned with the read data |
| edge_slot | output | 2 | Slot number of the next edge |

## Verification
Assertions check on every cycle that the slot steps by one, that the echo clock toggles, that held read data stays stable while `rd_valid` is low, and that a selected read raises `rd_valid` after exactly two or three edges with a run of four words. They also check that a write start arms the burst and that a deselected write stores nothing. Other behaviour needs the bench's directed scenarios, because it concerns stored values. These are the placement of write words in the array, the forwarding of word 3 to a read in the next frame, the exclusion of a same-frame write from a read, and the proof that addresses and selects on slots 2 and 3 leave memory untouched.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int BURST = 4;
  localparam int PIPE  = 6;
  typedef logic [1:0] slot_t;
  localparam slot_t SLOT_RA  = 2'd0;
  localparam slot_t SLOT_WA  = 2'd1;
  localparam slot_t SLOT_K2  = 2'd2;
  localparam slot_t SLOT_KB2 = 2'd3;
endpackage

// File: rtl/qb_slot_gen.sv
module qb_slot_gen
  import qb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot_o
);
  slot_t slot_q, slot_d;

  always_comb slot_d = slot_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_RA;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot_q == $past(slot_q) + 2'd1);
endmodule

// File: rtl/qb_write_path.sv
module qb_write_path
  import qb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  localparam int WA_W  = ADDR_W + $clog2(BURST)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             slot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_sel_n_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              mem_we_o,
  output logic [WA_W-1:0]   mem_wa_o,
  output logic [WORD_W-1:0] mem_wd_o,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o
);
  logic              act_q, act_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              start;
  logic [1:0]        widx;

  always_comb begin
    start  = (slot_i == SLOT_WA) && !wr_sel_n_i;
    act_d  = act_q;
    base_d = base_q;
    if (slot_i == SLOT_WA) begin
      act_d = start;
      if (start) base_d = addr_i;
    end else if (slot_i == SLOT_RA) begin
      act_d = 1'b0;
    end
    widx        = slot_i - 2'd1;
    mem_we_o    = start || (act_q && slot_i != SLOT_WA);
    mem_wa_o    = {(start ? addr_i : base_q), widx};
    mem_wd_o    = wdata_i;
    fwd_valid_o = act_q && (slot_i == SLOT_RA);
    fwd_addr_o  = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
    end
  end

  // R3
  wr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SLOT_WA && !wr_sel_n_i) |=> (act_q && slot_i == SLOT_K2 && mem_we_o));
  // R6
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SLOT_WA && wr_sel_n_i) |=> !mem_we_o);
endmodule

// File: rtl/qb_array.sv
module qb_array
  import qb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  localparam int WA_W  = ADDR_W + $clog2(BURST),
  localparam int WORDS = BURST << ADDR_W
)(
  input  logic                         clk,
  input  logic                         we_i,
  input  logic [WA_W-1:0]              wa_i,
  input  logic [WORD_W-1:0]            wd_i,
  input  logic [ADDR_W-1:0]            ra_i,
  output logic [BURST-1:0][WORD_W-1:0] burst_o
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  for (genvar g = 0; g < BURST; g++) begin : g_rd
    assign burst_o[g] = mem[{ra_i, 2'(g)}];
  end
endmodule

// File: rtl/qb_read_path.sv
module qb_read_path
  import qb_pkg::*;
#(
  parameter int WORD_W = 18
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  slot_t                        slot_i,
  input  logic                         dll_on_i,
  input  logic                         rd_sel_n_i,
  input  logic [BURST-1:0][WORD_W-1:0] burst_i,
  input  logic                         fwd_hit_i,
  input  logic [WORD_W-1:0]            fwd_data_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic                         rvalid_o,
  output logic                         echo_o
);
  logic [WORD_W-1:0] bank_q [2][BURST];
  logic [WORD_W-1:0] ld_word [BURST];
  logic              wbank_q, wbank_d;
  logic [PIPE-1:0]   iss_q, iss_d, bk_q, bk_d;
  logic              issue, out_hit;
  logic [WORD_W-1:0] out_word, rdata_q, rdata_d;
  logic              rvalid_q, echo_q;
  logic [2:0]        lat, idx;

  always_comb begin
    issue   = (slot_i == SLOT_RA) && !rd_sel_n_i;
    wbank_d = issue ? ~wbank_q : wbank_q;
    iss_d   = {iss_q[PIPE-2:0], issue};
    bk_d    = {bk_q[PIPE-2:0], wbank_q};
    for (int i = 0; i < BURST; i++)
      ld_word[i] = (i == BURST-1 && fwd_hit_i) ? fwd_data_i : burst_i[i];
    lat      = dll_on_i ? 3'd3 : 3'd2;
    out_hit  = 1'b0;
    out_word = rdata_q;
    idx      = '0;
    for (int i = 0; i < BURST; i++) begin
      idx = lat + 3'(i) - 3'd1;
      if (iss_q[idx]) begin
        out_hit  = 1'b1;
        out_word = bank_q[bk_q[idx]][i];
      end
    end
    rdata_d = out_word;
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      for (int i = 0; i < BURST; i++) bank_q[wbank_q][i] <= ld_word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank_q  <= 1'b0;
      iss_q    <= '0;
      bk_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      echo_q   <= 1'b0;
    end else begin
      wbank_q  <= wbank_d;
      iss_q    <= iss_d;
      bk_q     <= bk_d;
      rvalid_q <= out_hit;
      echo_q   <= ~slot_i[0];
      if (out_hit) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign echo_o   = echo_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |-> $stable(rdata_o));
  // R5
  rd_lat15_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SLOT_RA && !rd_sel_n_i && dll_on_i) |-> ##4 rvalid_o);
  // R5
  rd_lat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == SLOT_RA && !rd_sel_n_i && !dll_on_i) |-> ##3 rvalid_o);
  // R4
  rd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_o) |=> rvalid_o ##1 rvalid_o ##1 rvalid_o);
  // R10
  echo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> echo_o != $past(echo_o));
endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
  import qb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  localparam int WA_W  = ADDR_W + $clog2(BURST)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dll_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              echo_clk,
  output logic [1:0]        edge_slot
);
  slot_t                        slot;
  logic                         mem_we, fwd_valid, fwd_hit;
  logic [WA_W-1:0]              mem_wa;
  logic [WORD_W-1:0]            mem_wd;
  logic [ADDR_W-1:0]            fwd_addr;
  logic [BURST-1:0][WORD_W-1:0] burst;

  qb_slot_gen u_slot (.clk(clk), .rst_n(rst_n), .slot_o(slot));

  qb_write_path #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .addr_i(addr),
    .wr_sel_n_i(wr_sel_n), .wdata_i(wr_data),
    .mem_we_o(mem_we), .mem_wa_o(mem_wa), .mem_wd_o(mem_wd),
    .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr));

  qb_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we_i(mem_we), .wa_i(mem_wa), .wd_i(mem_wd),
    .ra_i(addr), .burst_o(burst));

  assign fwd_hit = fwd_valid && (fwd_addr == addr);

  qb_read_path #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .dll_on_i(dll_on),
    .rd_sel_n_i(rd_sel_n), .burst_i(burst),
    .fwd_hit_i(fwd_hit), .fwd_data_i(wr_data),
    .rdata_o(rd_data), .rvalid_o(rd_valid), .echo_o(echo_clk));

  assign edge_slot = slot;
endmodule

// File: tb/sim_qburst_sram.sv
module sim_qburst_sram;
  localparam int AW = 4;
  localparam int W  = 18;

  logic          clk = 1'b0;
  logic          rst_n, dll_on, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [W-1:0]  wr_data, rd_data;
  logic          rd_valid, echo_clk;
  logic [1:0]    edge_slot;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;
  logic [W-1:0] refm [16][4];
  int           exp_edge [$];
  logic [W-1:0] exp_data [$];
  string        exp_tag  [$];
  logic [W-1:0] pend_w3 = '0;
  logic [W-1:0] prev_rd = '0;

  qburst_sram #(.ADDR_W(AW), .WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dll_on(dll_on), .addr(addr),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .echo_clk(echo_clk),
    .edge_slot(edge_slot));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int a, int i, int salt);
    return W'((a * 613 + i * 97 + salt * 4099 + 17) & 32'h3FFFF);
  endfunction

  // Monitor: every edge after reset, check echo, slot, hold and read stream
  always begin
    int ix;
    @(posedge clk);
    if (rst_n) begin
      ix = ecount;
      ecount++;
      #2;
      chk(echo_clk == (ix % 2 == 0), "R10 echo_clk", echo_clk, (ix % 2 == 0));
      chk(edge_slot == 2'((ix + 1) % 4), "R2 edge_slot", edge_slot, (ix + 1) % 4);
      if (rd_valid) begin
        if (exp_edge.size() != 0 && exp_edge[0] == ix) begin
          chk(rd_data == exp_data[0], exp_tag[0], rd_data, exp_data[0]);
          void'(exp_edge.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
        end else begin
          chk(1'b0, "R4/R6 unexpected rd_valid", 1, 0);
        end
      end else begin
        chk(rd_data == prev_rd, "R9 rd_data hold", rd_data, prev_rd);
        if (exp_edge.size() != 0 && exp_edge[0] <= ix) begin
          chk(1'b0, {exp_tag[0], " missing rd_valid"}, 0, 1);
          void'(exp_edge.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
        end
      end
      prev_rd = rd_data;
    end
  end

  // One frame of four edges; call with edge_slot==0 at a falling edge
  task automatic run_frame(input bit rd, input int ra, input bit wr, input int wa,
                           input logic [W-1:0] w0, w1, w2, w3, input bit noise, input string tag);
    int base, lat;
    chk(edge_slot == 2'd0, "R2 frame alignment", edge_slot, 0);
    base = ecount;
    lat  = dll_on ? 3 : 2;
    if (rd) begin
      for (int i = 0; i < 4; i++) begin
        exp_edge.push_back(base + lat + i);
        exp_data.push_back(refm[ra][i]);
        exp_tag.push_back(tag);
      end
    end
    if (wr) begin
      refm[wa][0] = w0; refm[wa][1] = w1; refm[wa][2] = w2; refm[wa][3] = w3;
    end
    addr = AW'(ra); rd_sel_n = !rd; wr_sel_n = !noise; wr_data = pend_w3;
    @(negedge clk);
    addr = AW'(wa); wr_sel_n = !wr; rd_sel_n = !noise; wr_data = w0;
    @(negedge clk);
    addr = noise ? AW'(11) : '0; rd_sel_n = !noise; wr_sel_n = !noise; wr_data = w1;
    @(negedge clk);
    wr_data = w2;
    @(negedge clk);
    pend_w3 = wr ? w3 : pat(11, 3, 99);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) run_frame(0, 0, 0, 0, pat(1,0,50), pat(1,1,50), pat(1,2,50), pat(1,3,50), 0, "idle");
  endtask

  task automatic drain(input string tag);
    idle(2);
    chk(exp_edge.size() == 0, {tag, " all words delivered"}, exp_edge.size(), 0);
  endtask

  task automatic read_burst(input int a, input string tag);
    run_frame(1, a, 0, 0, pat(a,0,77), pat(a,1,77), pat(a,2,77), pat(a,3,77), 0, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; dll_on = 1'b1; addr = '0; rd_sel_n = 1'b1; wr_sel_n = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    chk(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
    chk(echo_clk == 1'b0, "R1 echo_clk in reset", echo_clk, 0);
    chk(edge_slot == 2'd0, "R1 edge_slot in reset", edge_slot, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_preload;
    for (int a = 0; a < 16; a++)
      run_frame(0, 0, 1, a, pat(a,0,1), pat(a,1,1), pat(a,2,1), pat(a,3,1), 0, "R3 preload");
    idle(1);
  endtask

  task automatic t_read_slow;
    read_burst(3, "R3 R4 R5 read dll_on=1");
    idle(1);
    read_burst(7, "R4 R5 read dll_on=1");
    drain("R5");
  endtask

  task automatic t_read_fast;
    dll_on = 1'b0;
    read_burst(5, "R4 R5 read dll_on=0");
    drain("R5");
    dll_on = 1'b1;
  endtask

  task automatic t_stream;
    for (int a = 0; a < 6; a++) read_burst(a, "R8 stream dll_on=1");
    drain("R8");
    dll_on = 1'b0;
    for (int a = 15; a > 9; a--) read_burst(a, "R8 stream dll_on=0");
    drain("R8");
    dll_on = 1'b1;
  endtask

  task automatic t_coherency;
    run_frame(0, 0, 1, 9, pat(9,0,2), pat(9,1,2), pat(9,2,2), pat(9,3,2), 0, "R7 write");
    read_burst(9, "R7 read after write incl word3");
    run_frame(1, 9, 1, 9, pat(9,0,3), pat(9,1,3), pat(9,2,3), pat(9,3,3), 0, "R7 read excludes same-frame write");
    read_burst(9, "R7 read sees newest write");
    drain("R7");
  endtask

  task automatic t_deselect;
    run_frame(0, 0, 0, 2, pat(2,0,4), pat(2,1,4), pat(2,2,4), pat(2,3,4), 0, "R6");
    run_frame(0, 2, 0, 0, pat(0,0,4), pat(0,1,4), pat(0,2,4), pat(0,3,4), 0, "R6");
    read_burst(2, "R6 deselected write stored nothing");
    drain("R6");
  endtask

  task automatic t_ignored_slots;
    for (int k = 0; k < 3; k++)
      run_frame(0, 0, 0, 0, pat(11,0,5), pat(11,1,5), pat(11,2,5), pat(11,3,5), 1, "R2 noise");
    read_burst(11, "R2 slots 2/3 ignored");
    drain("R2");
  endtask

  task automatic t_concurrent;
    for (int k = 0; k < 3; k++)
      run_frame(1, 4, 1, 12, pat(12,0,6+k), pat(12,1,6+k), pat(12,2,6+k), pat(12,3,6+k), 0, "R4 R3 concurrent");
    read_burst(12, "R3 concurrent write stored");
    drain("R3");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_preload;
    t_read_slow;
    t_read_fast;
    t_stream;
    t_coherency;
    t_deselect;
    t_ignored_slots;
    t_concurrent;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule